// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital controller of a charge-redistribution successive-approximation converter with 14 result bits. While idle it holds the acquisition configuration. The comparator-side terminals of the capacitor arrays are tied to ground, and the bottom plates connect to the analog inputs. The comparator is powered down and the DAC control word is zero.

A start request moves the block out of acquisition through a fixed switch-opening sequence. The comparator-side grounding opens first. One cycle later the bottom plates move from the inputs to ground. The block then runs one binary-search trial per bit, most significant bit first. Each trial sets the bit under test and waits a settle interval. It keeps the bit only if the comparator reports that the DAC level is at or below the held input.

After the last trial the block latches the straight-binary code and pulses a done flag. It then returns to the powered-down acquisition state. Everything runs on the block's own clock, and a start request that arrives during a conversion has no effect.

States, in order: `ST_ACQ` (acquiring, idle), `ST_OPEN` (top grounding open, plates still on inputs), `ST_MOVE` (plates moved to ground), `ST_SETTLE` (trial bit applied, waiting), `ST_DECIDE` (comparator sampled). Transitions:
- `ST_ACQ` goes to `ST_OPEN` on start.
- `ST_OPEN` goes to `ST_MOVE`, and `ST_MOVE` goes to `ST_SETTLE`.
- `ST_SETTLE` goes to `ST_DECIDE` after `SETTLE_CYC` cycles.
- `ST_DECIDE` goes back to `ST_SETTLE` for the next lower bit. After bit 0 it goes to `ST_ACQ`.

Top module: `sar_seq_ctrl`

## Requirements
- R1: While reset is held and directly after it, busy_o=0, done_o=0, result_o=0, dac_o=0, comp_en_o=0, top_gnd_o=1 and plate_in_o=1.
- R2: While busy_o is 0, the block is in acquisition: top_gnd_o=1, plate_in_o=1, comp_en_o=0 and dac_o=0.
- R3: In the first cycle after start_i is accepted, top_gnd_o is 0 while plate_in_o is still 1. In the following cycle plate_in_o is 0 and comp_en_o is 1. plate_in_o never falls unless top_gnd_o was already 0 in the cycle before.
- R4: Trials run from the most significant bit down. The first trial word on dac_o is 0x2000, with only bit 13 set. Each trial bit is held for SETTLE_CYC cycles (default 1) before the comparator is sampled.
- R5: A trial bit is kept when comp_le_i=1 (DAC at or below input) and cleared when it is 0. The result is straight binary: result_o equals the input level rounded down, in steps of 1/16384 of the reference.
- R6: An input above the top code gives 0x3FFF, and an input below zero gives 0x0000.
- R7: busy_o is high for exactly 2 + 14*(SETTLE_CYC+1) cycles (30 by default), starting in the cycle after start_i is accepted. done_o is a single-cycle pulse in the first cycle with busy_o low, and result_o already holds the new code in that cycle.
- R8: A start_i pulse while busy_o is 1 does not restart or lengthen the conversion, and does not change its result.
- R9: After done_o, result_o keeps its value until the next done_o. In the same cycle as done_o, the switches are back in acquisition and dac_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal conversion clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in acquisition only |
| comp_le_i | input | 1 | Comparator: 1 when the DAC level is at or below the held input |
| top_gnd_o | output | 1 | Closes the comparator-side grounding switches |
| plate_in_o | output | 1 | 1: array bottom plates on analog inputs; 0: on ground/DAC |
| comp_en_o | output | 1 | Comparator power enable |
| dac_o | output | 14 | Bit controls of the capacitor array |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse: new result valid |
| result_o | output | 14 | Last conversion code, straight binary |

## Verification
The bench targets both ends of the range. It drives inputs beyond the top code and below zero, plus codes next to the half-scale boundary (0x1FFF, 0x2000) and the extremes 0 and 1. A keep rule with the wrong polarity, or an off-by-one in the comparison, would miscount exactly these codes. The comparator model in the bench answers one cycle late, so a design that skipped the settle cycle would decide on the previous trial word and return wrong codes. The bench samples the switch outputs cycle by cycle, which exposes a design that moved the plates before opening the grounding. It also fires start pulses in the middle of conversions: a design that honoured them would show a busy window other than 30 cycles, or a second done pulse.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_ACQ    = 3'd0,
        ST_OPEN   = 3'd1,
        ST_MOVE   = 3'd2,
        ST_SETTLE = 3'd3,
        ST_DECIDE = 3'd4
    } sar_state_e;
endpackage

// File: rtl/sar_seq_fsm.sv
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       last_i,
    output sar_state_e state_o,
    output logic       arm_o,
    output logic       judge_o,
    output logic       finish_o
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(SETTLE_CYC - 1);

    sar_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACQ;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == ST_SETTLE && cnt_q != CNT_END) ? cnt_q + 1'b1 : '0;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACQ:    if (start_i) state_d = ST_OPEN;
            ST_OPEN:   state_d = ST_MOVE;
            ST_MOVE:   state_d = ST_SETTLE;
            ST_SETTLE: if (cnt_q == CNT_END) state_d = ST_DECIDE;
            ST_DECIDE: state_d = last_i ? ST_ACQ : ST_SETTLE;
            default:   state_d = ST_ACQ;
        endcase
    end

    // outputs
    always_comb begin
        state_o  = state_q;
        arm_o    = (state_q == ST_MOVE);
        judge_o  = (state_q == ST_DECIDE);
        finish_o = (state_q == ST_DECIDE) && last_i;
    end

    // R8: a conversion only begins from acquisition
    assert_open_from_acq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> $past(state_q) == ST_ACQ);
    // R4: comparator only judged after a settle interval
    assert_settle_before_judge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECIDE) |-> $past(state_q) == ST_SETTLE);
endmodule

// File: rtl/sar_seq_trial.sv
module sar_seq_trial #(
    parameter int NB = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_i,
    input  logic          judge_i,
    input  logic          comp_le_i,
    output logic [NB-1:0] dac_o,
    output logic [NB-1:0] final_o,
    output logic          last_o
);
    localparam logic [NB-1:0] MSB_HOT = {1'b1, {(NB-1){1'b0}}};

    logic [NB-1:0] ptr_q, ptr_d, dac_q, dac_d, kept;

    // per-bit decision: keep or drop the probed bit, raise the next one
    for (genvar i = 0; i < NB; i++) begin : g_bit
        if (i == NB - 1) begin : g_top
            assign kept[i] = (judge_i && ptr_q[i]) ? comp_le_i : dac_q[i];
        end else begin : g_low
            assign kept[i] = (judge_i && ptr_q[i])   ? comp_le_i :
                             (judge_i && ptr_q[i+1]) ? 1'b1      : dac_q[i];
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        dac_d = dac_q;
        if (arm_i) begin
            ptr_d = MSB_HOT;
            dac_d = MSB_HOT;
        end else if (judge_i) begin
            ptr_d = ptr_q >> 1;
            dac_d = ptr_q[0] ? '0 : kept;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            dac_q <= '0;
        end else begin
            ptr_q <= ptr_d;
            dac_q <= dac_d;
        end
    end

    assign dac_o   = dac_q;
    assign final_o = kept;
    assign last_o  = ptr_q[0];

    // R4: a single bit is under test at any time
    assert_one_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ptr_q));
    // R4: the first trial is the most significant bit alone
    assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> (dac_q == MSB_HOT));
endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int NBITS      = 14,
    parameter int SETTLE_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             comp_le_i,
    output logic             top_gnd_o,
    output logic             plate_in_o,
    output logic             comp_en_o,
    output logic [NBITS-1:0] dac_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [NBITS-1:0] result_o
);
    sar_state_e       state;
    logic             arm, judge, finish, last;
    logic [NBITS-1:0] final_code;
    logic [NBITS-1:0] result_q;
    logic             done_q;

    sar_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last),
        .state_o(state), .arm_o(arm), .judge_o(judge), .finish_o(finish)
    );

    sar_seq_trial #(.NB(NBITS)) u_trial (
        .clk(clk), .rst_n(rst_n), .arm_i(arm), .judge_i(judge),
        .comp_le_i(comp_le_i), .dac_o(dac_o), .final_o(final_code), .last_o(last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) result_q <= final_code;
        end
    end

    // switch and status decode
    always_comb begin
        busy_o     = (state != ST_ACQ);
        top_gnd_o  = (state == ST_ACQ);
        plate_in_o = (state == ST_ACQ) || (state == ST_OPEN);
        comp_en_o  = (state == ST_MOVE) || (state == ST_SETTLE) || (state == ST_DECIDE);
        done_o     = done_q;
        result_o   = result_q;
    end

    // R3: plates leave the inputs only after the top grounding has opened
    assert_gnd_open_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(plate_in_o) |-> $past(!top_gnd_o));
    assert_plates_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(top_gnd_o) |-> plate_in_o);
    // R2: idle means powered-down acquisition with a cleared DAC
    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (dac_o == '0) && !comp_en_o && top_gnd_o && plate_in_o);
    // R7: done follows the end of a conversion and never overlaps busy
    assert_done_after_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && $past(busy_o));
    // R9: result holds between completions
    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !finish |=> $stable(result_o));
endmodule

// File: tb/sar_seq_ctrl_tb.sv
module sar_seq_ctrl_tb;
    localparam int NB   = 14;
    localparam int BUSY = 2 + NB * 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic comp_le = 1'b0;
    logic top_gnd, plate_in, comp_en, busy, done;
    logic [NB-1:0] dac, result;
    int vin = 0;
    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sar_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .comp_le_i(comp_le),
        .top_gnd_o(top_gnd), .plate_in_o(plate_in), .comp_en_o(comp_en),
        .dac_o(dac), .busy_o(busy), .done_o(done), .result_o(result)
    );

    // comparator model with one cycle of latency (needs the settle cycle)
    always_ff @(posedge clk) comp_le <= (int'(dac) <= vin);

    function automatic int exp_code(int v);
        if (v < 0) return 0;
        if (v > 16383) return 16383;
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    task automatic convert(int v, int poke_at);
        int bcnt = 0;
        int dcnt = 0;
        @(negedge clk);
        vin = v; start = 1'b1;
        @(negedge clk);                       // after accept edge
        start = 1'b0;
        chk("R3 top open", int'(top_gnd), 0);
        chk("R3 plates still on input", int'(plate_in), 1);
        bcnt = 1;
        @(negedge clk);
        chk("R3 plates grounded", int'(plate_in), 0);
        chk("R3 comparator on", int'(comp_en), 1);
        bcnt++;
        @(negedge clk);
        chk("R4 msb first", int'(dac), 16'h2000);
        bcnt++;
        for (int k = 0; k < 80 && busy; k++) begin
            if (k == poke_at) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            if (busy) bcnt++;
            if (done) dcnt++;
        end
        chk("R7 busy length", bcnt, BUSY);
        chk("R7 done pulse", int'(done), 1);
        chk("R5/R6 result", int'(result), exp_code(v));
        chk("R9 back to acquisition", int'(top_gnd & plate_in & ~comp_en), 1);
        chk("R9 dac cleared", int'(dac), 0);
        @(negedge clk);
        chk("R7 done single", int'(done), 0);
        chk("R8 no restart", int'(busy), 0);
        chk("R9 result held", int'(result), exp_code(v));
        if (poke_at >= 0) chk("R8 single done", dcnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 result", int'(result), 0);
        chk("R1 switches", int'({top_gnd, plate_in, comp_en}), 3'b110);
        chk("R1 dac", int'(dac), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R2 idle acquisition", int'({top_gnd, plate_in, comp_en}), 3'b110);
        chk("R2 idle dac", int'(dac), 0);
        convert(8192, -1);
        convert(8191, -1);
        convert(0, -1);
        convert(1, -1);
        convert(16383, -1);
        convert(20000, -1);   // R6 overrange
        convert(-7, -1);      // R6 underrange
        convert(5461, 3);     // R8 start mid-conversion
        convert(12000, 20);   // R8 late start
        for (int n = 0; n < 40; n++) begin
            convert(int'($urandom_range(17400)) - 500, (n % 4 == 0) ? int'($urandom_range(25)) : -1);
        end
        finish_run();
    end
endmodule